// File: doc/BRIEF.md
# Debug module host register interface

This block is the register file that a debug host sees when it talks to a processor debug module. The host issues one word-addressed read or write per cycle over a simple request port. Each request gets a response one cycle later, carrying read data and an error flag. The block holds the control word, a small array of data words, a program buffer, the auto-execute masks and the abstract-command status with its sticky error field. It also builds a hart status word from the existence and halted flags of the currently selected hart.

Toward the rest of the debug module, the block drives a halt request to the selected hart. It issues a start pulse together with the stored command word whenever a command is launched. It issues a resume pulse when the host asks an existing hart to resume. A command decoder elsewhere reports back through three inputs: acceptance, which marks the command busy; completion, which clears busy; and a fault code. The decoder, the instruction generator and the fetch monitor are outside this block.

Top module: `dbg_host_regs`

## Requirements
- R1: After reset, the control word reads zero. The command-status word reads 0x0400_0002: buffer size 4 in bits 28:24, data count 2 in bits 3:0, busy (bit 12) clear and error (bits 10:8) zero. No halt request, start pulse or resume pulse is active.
- R2: Every request with `req_valid` high gets `rsp_valid` one cycle later. A read of an address that matches no register returns `rsp_err`=1 with data 0. A write to such an address returns `rsp_err`=0 and changes no register.
- R3: Data words sit at word addresses 0x04 and up, and program-buffer words at 0x20 and up. Each stores a full 32-bit write and returns it on a later read.
- R4: Control (address 0x10) is laid out as halt request bit 31, resume request bit 30, hart select bits 19:16, non-debug reset bit 1 and active bit 0. A write with bit 0 set loads these fields. A write with bit 0 clear zeroes the control word, the error field, busy and both auto-execute masks.
- R5: The status word (address 0x11) reflects only the selected hart. A hart select of 4 or more, or a hart whose existence flag is low, sets bits 15 and 14. Otherwise a halted hart sets bits 9 and 8, and a running hart sets bits 11 and 10. Bits 13 and 12 are zero, bit 7 is one, and bits 3:0 read 2.
- R6: The error field is sticky. A write to command status (address 0x16) clears it only when the written bits 10:8 are 0. Any other written value leaves it unchanged.
- R7: A read or write of a data word while busy is set and the error field is 0 sets the error field to the busy code 1.
- R8: The data auto-execute mask is held in auto-execute register (address 0x18) bits 1:0. A read or write of data word i, with mask bit i set, produces a one-cycle `cmd_start` pulse in the response cycle.
- R9: Reading the command register (address 0x17) returns 0. Writing it stores the value on `cmd_word` and produces a one-cycle `cmd_start` pulse in the response cycle.
- R10: A control write with active and resume set, naming an existing hart, sets busy and pulses `resume_go` for one cycle. Naming a non-existent hart does neither.
- R11: `cmd_accept` sets busy and `cmd_done` clears it. When both arrive in the same cycle, busy ends set.
- R12: A `cmd_fault` loads `cmd_fault_code` into the error field only while the field is 0. If a busy data access falls in the same cycle, the busy code 1 is recorded instead.
- R13: `halt_req` has at most one bit set: the bit of the selected hart, while the halt-request field is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Host request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Unmatched read |
| hart_exists | input | 4 | Per-hart existence flags |
| hart_halted | input | 4 | Per-hart halted flags |
| cmd_accept | input | 1 | Decoder accepted a command (sets busy) |
| cmd_done | input | 1 | Command finished (clears busy) |
| cmd_fault | input | 1 | Decoder reports an error |
| cmd_fault_code | input | 3 | Error code reported |
| cmd_start | output | 1 | Start-command pulse |
| cmd_word | output | 32 | Stored command value |
| halt_req | output | 4 | Halt request per hart |
| resume_go | output | 1 | Resume pulse for the selected hart |
| hart_sel | output | 4 | Selected hart |
| ndm_reset | output | 1 | Non-debug reset request |

## Verification
Two pairs of events can fall in the same cycle. The first is a host data access during busy together with a decoder fault report. The bench provokes it by holding `cmd_fault` high with code 2 across a data read while busy. The error field must then read the busy code 1, not 2. The second is `cmd_accept` and `cmd_done` raised in one cycle; the bench requires busy to read as set afterward.

// File: rtl/dbg_host_regs.sv
module dbg_host_regs #(
  parameter int NHARTS = 4,
  parameter int SEL_W  = 4,
  parameter int NDATA  = 2,
  parameter int NPROG  = 4,
  parameter int AW     = 7
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  input  logic [NHARTS-1:0] hart_exists,
  input  logic [NHARTS-1:0] hart_halted,
  input  logic              cmd_accept,
  input  logic              cmd_done,
  input  logic              cmd_fault,
  input  logic [2:0]        cmd_fault_code,
  output logic              cmd_start,
  output logic [31:0]       cmd_word,
  output logic [NHARTS-1:0] halt_req,
  output logic              resume_go,
  output logic [SEL_W-1:0]  hart_sel,
  output logic              ndm_reset
);
  localparam int A_DATA = 4, A_CTRL = 16, A_STAT = 17, A_ACS = 22;
  localparam int A_CMD = 23, A_AUTO = 24, A_PROG = 32;
  localparam int DIW = NDATA  > 1 ? $clog2(NDATA)  : 1;
  localparam int PIW = NPROG  > 1 ? $clog2(NPROG)  : 1;
  localparam int HIW = NHARTS > 1 ? $clog2(NHARTS) : 1;
  localparam logic [2:0] ERR_BUSY = 3'd1;

  logic [31:0]      data_q [NDATA];
  logic [31:0]      prog_q [NPROG];
  logic             active_q, halt_q, resume_q, busy_q;
  logic [2:0]       err_q;
  logic [NDATA-1:0] auto_data_q;
  logic [NPROG-1:0] auto_prog_q;
  logic [31:0]      rd;
  logic             hit;

  function automatic logic hart_there(logic [SEL_W-1:0] s, logic [NHARTS-1:0] ex);
    return (32'(s) < NHARTS) && ex[HIW'(s)];
  endfunction

  logic [31:0] a32;
  assign a32 = 32'(req_addr);

  logic is_data, is_prog, wr, ctrl_wr, deact, resume_fire, data_acc, sel_ok;
  logic [DIW-1:0] didx;
  logic [PIW-1:0] pidx;
  assign is_data     = a32 >= A_DATA && a32 < A_DATA + NDATA;
  assign is_prog     = a32 >= A_PROG && a32 < A_PROG + NPROG;
  assign didx        = DIW'(a32 - A_DATA);
  assign pidx        = PIW'(a32 - A_PROG);
  assign wr          = req_valid && req_write;
  assign ctrl_wr     = wr && a32 == A_CTRL;
  assign deact       = ctrl_wr && !req_wdata[0];
  assign resume_fire = ctrl_wr && req_wdata[0] && req_wdata[30] &&
                       hart_there(req_wdata[16 +: SEL_W], hart_exists);
  assign data_acc    = req_valid && is_data;
  assign sel_ok      = hart_there(hart_sel, hart_exists);

  always_comb begin
    rd  = '0;
    hit = 1'b1;
    if (is_data) rd = data_q[didx];
    else if (is_prog) rd = prog_q[pidx];
    else begin
      case (a32)
        A_CTRL: begin
          rd[31] = halt_q;
          rd[30] = resume_q;
          rd[16 +: SEL_W] = hart_sel;
          rd[1] = ndm_reset;
          rd[0] = active_q;
        end
        A_STAT: begin
          rd[15:14] = {2{!sel_ok}};
          rd[11:10] = {2{sel_ok && !hart_halted[HIW'(hart_sel)]}};
          rd[9:8]   = {2{sel_ok &&  hart_halted[HIW'(hart_sel)]}};
          rd[7]     = 1'b1;
          rd[3:0]   = 4'd2;
        end
        A_ACS: begin
          rd[28:24] = 5'(NPROG);
          rd[12]    = busy_q;
          rd[10:8]  = err_q;
          rd[3:0]   = 4'(NDATA);
        end
        A_CMD:  rd = '0;
        A_AUTO: begin
          rd[16 +: NPROG] = auto_prog_q;
          rd[NDATA-1:0]   = auto_data_q;
        end
        default: hit = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NDATA; i++) data_q[i] <= '0;
      for (int i = 0; i < NPROG; i++) prog_q[i] <= '0;
    end else if (wr) begin
      if (is_data) data_q[didx] <= req_wdata;
      if (is_prog) prog_q[pidx] <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0; rsp_rdata <= '0; rsp_err <= 1'b0;
      cmd_start <= 1'b0; cmd_word <= '0; resume_go <= 1'b0;
      active_q <= 1'b0; halt_q <= 1'b0; resume_q <= 1'b0; ndm_reset <= 1'b0;
      hart_sel <= '0; busy_q <= 1'b0; err_q <= '0;
      auto_data_q <= '0; auto_prog_q <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write && hit) ? rd : '0;
      rsp_err   <= req_valid && !req_write && !hit;
      cmd_start <= (data_acc && auto_data_q[didx]) || (wr && a32 == A_CMD);
      resume_go <= resume_fire;
      if (wr && a32 == A_CMD) cmd_word <= req_wdata;
      if (ctrl_wr) begin
        active_q  <= req_wdata[0];
        halt_q    <= req_wdata[0] && req_wdata[31];
        resume_q  <= req_wdata[0] && req_wdata[30];
        ndm_reset <= req_wdata[0] && req_wdata[1];
        hart_sel  <= req_wdata[0] ? req_wdata[16 +: SEL_W] : '0;
      end
      if (deact) begin
        busy_q <= 1'b0;
        err_q <= '0;
        auto_data_q <= '0;
        auto_prog_q <= '0;
      end else begin
        busy_q <= (busy_q && !cmd_done) || cmd_accept || resume_fire;
        if (wr && a32 == A_AUTO) begin
          auto_data_q <= req_wdata[NDATA-1:0];
          auto_prog_q <= req_wdata[16 +: NPROG];
        end
        if (wr && a32 == A_ACS) begin
          if (req_wdata[10:8] == 3'd0) err_q <= '0;
        end else if (err_q == 3'd0) begin
          if (data_acc && busy_q) err_q <= ERR_BUSY;
          else if (cmd_fault) err_q <= cmd_fault_code;
        end
      end
    end
  end

  always_comb
    for (int h = 0; h < NHARTS; h++)
      halt_req[h] = halt_q && (32'(hart_sel) == h);
endmodule

// File: rtl/dbg_host_regs_chk.sv
module dbg_host_regs_chk #(
  parameter int NHARTS = 4,
  parameter int NDATA  = 2,
  parameter int AW     = 7
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic [AW-1:0]     req_addr,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [31:0]       rsp_rdata,
  input logic              cmd_start,
  input logic              resume_go,
  input logic [NHARTS-1:0] halt_req,
  input logic [2:0]        err_q,
  input logic              busy_q
);
  logic [31:0] a32;
  assign a32 = 32'(req_addr);

  assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_err_data_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 32'd0 && rsp_valid));
  assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_q != 3'd0 && !(req_valid && req_write && (a32 == 22 || a32 == 16)))
    |=> $stable(err_q));
  assert_busy_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && a32 >= 4 && a32 < 4 + NDATA && busy_q && err_q == 3'd0)
    |=> err_q == 3'd1);
  assert_cmd_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && a32 == 23) |=> cmd_start);
  assert_resume_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    resume_go |-> busy_q);
  assert_halt_onehot_R13: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(halt_req));
endmodule

bind dbg_host_regs dbg_host_regs_chk #(.NHARTS(NHARTS), .NDATA(NDATA), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata), .cmd_start(cmd_start), .resume_go(resume_go),
  .halt_req(halt_req), .err_q(err_q), .busy_q(busy_q));

// File: tb/dbg_host_regs_bench.sv
`timescale 1ns/1ps
module dbg_host_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0;
  logic [6:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid, rsp_err, cmd_start, resume_go, ndm_reset;
  logic [31:0] rsp_rdata, cmd_word;
  logic [3:0] hart_exists = 4'b1111, hart_halted = 4'b0000, halt_req, hart_sel;
  logic cmd_accept = 0, cmd_done = 0, cmd_fault = 0;
  logic [2:0] cmd_fault_code = '0;

  always #2 clk = ~clk;

  dbg_host_regs u_dbg_host_regs (.*);

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];
  logic s_start, s_resume;

  localparam logic [31:0] ACS0 = 32'h0400_0002;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic access(bit w, logic [6:0] a, logic [31:0] d,
                        logic [31:0] exp_d, logic exp_e, string tag);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    q_data.push_back(exp_d); q_err.push_back(exp_e); q_tag.push_back(tag);
    @(posedge clk); #1;
    req_valid = 0;
    s_start = cmd_start; s_resume = resume_go;
    @(negedge clk);
  endtask

  task automatic pulse(bit acc, bit done);
    cmd_accept = acc; cmd_done = done;
    @(posedge clk); #1;
    cmd_accept = 0; cmd_done = 0;
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rsp_valid) begin
      if (q_data.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected response actual 0x%08h expected none", rsp_rdata);
      end else begin
        automatic logic [31:0] ed = q_data.pop_front();
        automatic logic ee = q_err.pop_front();
        automatic string t = q_tag.pop_front();
        check({t, " data"}, rsp_rdata, ed);
        check({t, " err"}, {31'd0, rsp_err}, {31'd0, ee});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 halt_req", {28'd0, halt_req}, 32'd0);
    check("R1 cmd_start", {31'd0, cmd_start}, 32'd0);
    access(0, 7'h16, 0, ACS0, 0, "R1 acs");
    access(0, 7'h10, 0, 32'd0, 0, "R1 ctrl");
    // R5 hart 0 running
    access(0, 7'h11, 0, 32'h0000_0C82, 0, "R5 running");
    // R2 unmatched
    access(0, 7'h3F, 0, 32'd0, 1, "R2 unmatched read");
    access(1, 7'h3F, 32'hFFFF_FFFF, 32'd0, 0, "R2 unmatched write");
    access(0, 7'h16, 0, ACS0, 0, "R2 no effect");
    // R3 storage
    access(1, 7'h04, 32'h1234_5678, 0, 0, "R3 wr d0");
    access(1, 7'h05, 32'hCAFE_0001, 0, 0, "R3 wr d1");
    access(1, 7'h23, 32'hA5A5_5A5A, 0, 0, "R3 wr p3");
    access(0, 7'h04, 0, 32'h1234_5678, 0, "R3 rd d0");
    access(0, 7'h05, 0, 32'hCAFE_0001, 0, "R3 rd d1");
    access(0, 7'h23, 0, 32'hA5A5_5A5A, 0, "R3 rd p3");
    // R4 / R13 control
    access(1, 7'h10, 32'h8002_0003, 0, 0, "R4 ctrl wr");
    access(0, 7'h10, 0, 32'h8002_0003, 0, "R4 ctrl rd");
    check("R13 halt_req", {28'd0, halt_req}, 32'h4);
    check("R4 ndm_reset", {31'd0, ndm_reset}, 32'd1);
    hart_halted = 4'b0100;
    access(0, 7'h11, 0, 32'h0000_0382, 0, "R5 halted");
    access(1, 7'h10, 32'h0005_0001, 0, 0, "R4 sel5");
    check("R13 halt dropped", {28'd0, halt_req}, 32'd0);
    access(0, 7'h11, 0, 32'h0000_C082, 0, "R5 nonexistent");
    // R9 command
    access(1, 7'h17, 32'h0022_1005, 0, 0, "R9 cmd wr");
    check("R9 start", {31'd0, s_start}, 32'd1);
    check("R9 word", cmd_word, 32'h0022_1005);
    access(0, 7'h17, 0, 32'd0, 0, "R9 cmd rd");
    check("R9 no start on read", {31'd0, s_start}, 32'd0);
    // R8 autoexec
    access(1, 7'h18, 32'h0000_0002, 0, 0, "R8 auto wr");
    access(0, 7'h18, 0, 32'h0000_0002, 0, "R8 auto rd");
    access(0, 7'h04, 0, 32'h1234_5678, 0, "R8 d0");
    check("R8 d0 no start", {31'd0, s_start}, 32'd0);
    access(1, 7'h05, 32'h0000_0077, 0, 0, "R8 d1 wr");
    check("R8 d1 start", {31'd0, s_start}, 32'd1);
    // R11 / R7 busy
    pulse(1, 0);
    access(0, 7'h16, 0, ACS0 | 32'h1000, 0, "R11 busy set");
    access(0, 7'h04, 0, 32'h1234_5678, 0, "R7 busy access");
    access(0, 7'h16, 0, ACS0 | 32'h1100, 0, "R7 busy err");
    // R6 sticky
    access(1, 7'h16, 32'h0000_0300, 0, 0, "R6 wr nonzero");
    access(0, 7'h16, 0, ACS0 | 32'h1100, 0, "R6 still set");
    access(1, 7'h16, 32'h0000_0000, 0, 0, "R6 wr zero");
    access(0, 7'h16, 0, ACS0 | 32'h1000, 0, "R6 cleared");
    // R12 same cycle: busy access and fault code 2
    cmd_fault = 1; cmd_fault_code = 3'd2;
    access(0, 7'h04, 0, 32'h1234_5678, 0, "R12 combo");
    cmd_fault = 0;
    access(0, 7'h16, 0, ACS0 | 32'h1100, 0, "R12 busy wins");
    access(1, 7'h16, 32'd0, 0, 0, "R12 clr");
    pulse(0, 1);
    access(0, 7'h16, 0, ACS0, 0, "R11 busy cleared");
    cmd_fault = 1; cmd_fault_code = 3'd3;
    @(posedge clk); #1; cmd_fault = 1; cmd_fault_code = 3'd5;
    @(negedge clk); cmd_fault = 0;
    access(0, 7'h16, 0, ACS0 | 32'h0300, 0, "R12 first fault kept");
    access(1, 7'h16, 32'd0, 0, 0, "R12 clr2");
    // R11 simultaneous accept and done
    pulse(1, 1);
    access(0, 7'h16, 0, ACS0 | 32'h1000, 0, "R11 set wins");
    pulse(0, 1);
    // R10 resume
    access(1, 7'h10, 32'h4001_0001, 0, 0, "R10 resume h1");
    check("R10 resume_go", {31'd0, s_resume}, 32'd1);
    access(0, 7'h16, 0, ACS0 | 32'h1000, 0, "R10 busy");
    pulse(0, 1);
    access(1, 7'h10, 32'h4005_0001, 0, 0, "R10 resume h5");
    check("R10 no resume_go", {31'd0, s_resume}, 32'd0);
    access(0, 7'h16, 0, ACS0, 0, "R10 not busy");
    // R4 deactivate
    access(1, 7'h10, 32'h8001_0001, 0, 0, "R4 halt h1");
    check("R13 halt h1", {28'd0, halt_req}, 32'h2);
    pulse(1, 0);
    access(0, 7'h04, 0, 32'h1234_5678, 0, "R4 err setup");
    access(1, 7'h10, 32'h8001_0000, 0, 0, "R4 deactivate");
    check("R4 halt dropped", {28'd0, halt_req}, 32'd0);
    access(0, 7'h10, 0, 32'd0, 0, "R4 ctrl cleared");
    access(0, 7'h16, 0, ACS0, 0, "R4 acs cleared");
    access(0, 7'h18, 0, 32'd0, 0, "R4 auto cleared");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule